// File: doc/BRIEF.md
# Clock Fan-Out Output Gating Controller

This block takes one reference clock and delivers it to eight output channels. Each channel has its own output clock and its own drive flag, which tells the pad whether it should drive or float. Before fan-out, the reference can be halved or passed through at full rate. Each channel drives only when three things hold: its enable pin is effective, its bit in the register bank allows it, and neither the global stop nor the power-down control is effective. A single polarity pin reverses the sense of the enable, stop and power-down pins together.

The reference clock is sampled by a faster system clock, and every output is registered in that domain. The control pins pass through a two-stage synchronizer before they are used. A channel can switch between driven and floating only while the selected source clock is low, so an output never emits a shortened high pulse. A sticky lock flag rises when the raw lock input is seen. It falls only on effective power-down or on reset.

Top module: `clk_fanout_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, `clk_out`, `out_drive` and `lock_out` are all 0.
- R2: With the reference held low, `out_drive[i]` settles to 1 exactly when `chan_en_pin[i] ^ pol_inv` is 1, `reg_en[i]` is 1, `stop_pin != pol_inv` and `pdn_pin != pol_inv`.
- R3: With `pol_inv` at 1, the enable pins count as active low, and the stop and power-down pins count as active high. With `pol_inv` at 0, the enables are active high, and stop and power-down are active low.
- R4: An effective stop or power-down clears every bit of `out_drive`, whatever the enable pins and register bits say.
- R5: A 0 in `reg_en[i]` clears `out_drive[i]` on its own, and leaves the other channels unaffected.
- R6: With `div_sel_n` at 1, each enabled output has one rising edge per reference rising edge. With `div_sel_n` at 0, it has one rising edge per two reference rising edges.
- R7: `out_drive` changes only in cycles that follow a low level of the selected source clock. Every high pulse on `clk_out` is therefore as wide as a full high phase of the source clock: 2 system cycles undivided and 4 cycles divided, when the reference toggles every 2 cycles.
- R8: A channel whose `out_drive` is 0 holds its `clk_out` at 0.
- R9: `lock_out` rises after `lock_raw` is seen high and stays high after `lock_raw` returns low.
- R10: An effective power-down clears `lock_out`, and so does reset.
- R11: A change on a control pin, sampled at a rising edge, reaches `out_drive` on the third rising edge counted from that one, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the reference |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock, sampled level |
| div_sel_n | input | 1 | 0 selects the halved reference |
| chan_en_pin | input | 8 | Per-channel enable pins |
| pol_inv | input | 1 | Reverses the sense of enable, stop and power-down pins |
| stop_pin | input | 1 | Global stop, active low by default |
| pdn_pin | input | 1 | Power-down, active low by default |
| reg_en | input | 8 | Per-channel enable bits from the register bank |
| lock_raw | input | 1 | Raw lock indication |
| clk_out | output | 8 | Gated output clocks |
| out_drive | output | 8 | 1 = channel driven, 0 = floating |
| lock_out | output | 1 | Sticky lock flag |

## Verification
The assertions assume that `ref_clk` changes only between system clock edges. They also assume that each level of the reference lasts at least one system cycle, so the sampled source clock is a clean square wave. The bench meets this by moving the reference only on falling system edges, with a fixed half-period of two cycles. It changes the control pins at those same falling edges, so every pin is seen at a single rising edge by the synchronizer. The no-runt and divide checks are made with this steady reference running. The decode sweep holds the reference low, so the gating has no blocked window.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;

  localparam int SYNC_STAGES = 2;

  // A control that is active low by default is asserted when its level
  // equals the polarity-invert setting.
  function automatic logic ctl_asserted(input logic pin, input logic inv);
    return pin == inv;
  endfunction

endpackage

// File: rtl/cf_sync.sv
module cf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g+1] <= '0;
      else     chain[g+1] <= chain[g];
    end
  end

  assign q = chain[STAGES];

endmodule

// File: rtl/cf_divider.sv
module cf_divider (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic div_en,
  output logic src
);

  logic ref_q;
  logic ref_q2;
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= 1'b0;
      ref_q2 <= 1'b0;
      half_q <= 1'b0;
    end else begin
      ref_q  <= ref_in;
      ref_q2 <= ref_q;
      if (ref_q && !ref_q2) half_q <= ~half_q;
    end
  end

  assign src = div_en ? half_q : ref_q;

endmodule

// File: rtl/cf_chan_gate.sv
module cf_chan_gate (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic want,
  output logic clk_o,
  output logic drv_o
);

  logic drv_next;

  // The drive decision is only re-evaluated while the source is low.
  assign drv_next = src ? drv_o : want;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_o <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      drv_o <= drv_next;
      clk_o <= src & drv_next;
    end
  end

endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
  import clk_fanout_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_clk,
  input  logic           div_sel_n,
  input  logic [NCH-1:0] chan_en_pin,
  input  logic           pol_inv,
  input  logic           stop_pin,
  input  logic           pdn_pin,
  input  logic [NCH-1:0] reg_en,
  input  logic           lock_raw,
  output logic [NCH-1:0] clk_out,
  output logic [NCH-1:0] out_drive,
  output logic           lock_out
);

  localparam int SW       = NCH + 5;
  localparam int IDX_LOCK = NCH;
  localparam int IDX_PDN  = NCH + 1;
  localparam int IDX_STOP = NCH + 2;
  localparam int IDX_INV  = NCH + 3;
  localparam int IDX_DIV  = NCH + 4;

  logic [SW-1:0]  pins_a;
  logic [SW-1:0]  pins_s;
  logic [NCH-1:0] en_eff;
  logic [NCH-1:0] want;
  logic           inv_s;
  logic           stop_eff;
  logic           pdn_eff;
  logic           sel_clk;

  assign pins_a = {div_sel_n, pol_inv, stop_pin, pdn_pin, lock_raw, chan_en_pin};

  cf_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_a),
    .q   (pins_s)
  );

  assign inv_s    = pins_s[IDX_INV];
  assign stop_eff = ctl_asserted(pins_s[IDX_STOP], inv_s);
  assign pdn_eff  = ctl_asserted(pins_s[IDX_PDN], inv_s);
  assign en_eff   = pins_s[NCH-1:0] ^ {NCH{inv_s}};
  assign want     = en_eff & reg_en & {NCH{~(stop_eff | pdn_eff)}};

  cf_divider u_div (
    .clk    (clk),
    .rst    (rst),
    .ref_in (ref_clk),
    .div_en (~pins_s[IDX_DIV]),
    .src    (sel_clk)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    cf_chan_gate u_gate (
      .clk   (clk),
      .rst   (rst),
      .src   (sel_clk),
      .want  (want[i]),
      .clk_o (clk_out[i]),
      .drv_o (out_drive[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || pdn_eff) lock_out <= 1'b0;
    else                lock_out <= lock_out | pins_s[IDX_LOCK];
  end

endmodule

// File: rtl/cf_checker.sv
module cf_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           src,
  input logic           stop_eff,
  input logic           pdn_eff,
  input logic [NCH-1:0] clk_out,
  input logic [NCH-1:0] out_drive,
  input logic           lock_out
);

  AST_DRIVE_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    src |=> $stable(out_drive)); // R7

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (rst)
    ((stop_eff || pdn_eff) && !src) |=> (out_drive == '0)); // R4

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (lock_out && !pdn_eff) |=> lock_out); // R9

  AST_LOCK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    pdn_eff |=> !lock_out); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
      !out_drive[i] |-> !clk_out[i]); // R8

    AST_NO_EARLY_HIGH: assert property (@(posedge clk) disable iff (rst)
      !src |=> !clk_out[i]); // R7
  end

endmodule

bind clk_fanout_gate cf_checker #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src       (sel_clk),
  .stop_eff  (stop_eff),
  .pdn_eff   (pdn_eff),
  .clk_out   (clk_out),
  .out_drive (out_drive),
  .lock_out  (lock_out)
);

// File: tb/clk_fanout_gate_test.sv
`timescale 1ns/1ps
module clk_fanout_gate_test;

  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           ref_clk = 1'b0;
  logic           div_sel_n = 1'b1;
  logic [NCH-1:0] chan_en_pin = '0;
  logic           pol_inv = 1'b0;
  logic           stop_pin = 1'b1;
  logic           pdn_pin = 1'b1;
  logic [NCH-1:0] reg_en = '0;
  logic           lock_raw = 1'b0;
  logic [NCH-1:0] clk_out;
  logic [NCH-1:0] out_drive;
  logic           lock_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  clk_fanout_gate #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .div_sel_n(div_sel_n),
    .chan_en_pin(chan_en_pin), .pol_inv(pol_inv), .stop_pin(stop_pin),
    .pdn_pin(pdn_pin), .reg_en(reg_en), .lock_raw(lock_raw),
    .clk_out(clk_out), .out_drive(out_drive), .lock_out(lock_out)
  );

  always #2 clk = ~clk;

  // Reference generator: toggles every 2 system cycles on falling edges.
  bit ref_run = 0;
  int ref_cnt = 0;
  always @(negedge clk) begin
    if (ref_run) begin
      ref_cnt++;
      if (ref_cnt == 2) begin
        ref_clk = ~ref_clk;
        ref_cnt = 0;
      end
    end else begin
      ref_clk = 1'b0;
      ref_cnt = 0;
    end
  end

  // Output monitor: rising-edge counts and high-pulse widths.
  bit meas = 0;
  int exp_w = 2;
  int rises [NCH];
  int hlen  [NCH];
  bit hval  [NCH];
  int width_bad = 0;
  int pulses = 0;
  logic [NCH-1:0] prev_out = '0;
  always @(negedge clk) begin
    if (meas) begin
      for (int i = 0; i < NCH; i++) begin
        if (clk_out[i] && !prev_out[i]) begin
          rises[i]++;
          hlen[i] = 1;
          hval[i] = 1;
        end else if (clk_out[i]) begin
          hlen[i]++;
        end else if (prev_out[i] && hval[i]) begin
          pulses++;
          if (hlen[i] != exp_w) width_bad++;
        end
      end
    end
    prev_out = clk_out;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_meas();
    for (int i = 0; i < NCH; i++) begin
      rises[i] = 0; hlen[i] = 0; hval[i] = 0;
    end
    width_bad = 0;
    pulses = 0;
  endtask

  task automatic run_count(input bit divided);
    int lo, hi;
    div_sel_n = divided ? 1'b0 : 1'b1;
    chan_en_pin = '1; pol_inv = 0; stop_pin = 1; pdn_pin = 1;
    reg_en = 8'hF7;
    ref_run = 1;
    cyc(30);
    clear_meas();
    meas = 1;
    cyc(400);
    meas = 0;
    lo = divided ? 49 : 99;
    hi = divided ? 51 : 101;
    for (int i = 0; i < NCH; i++) begin
      if (i == 3) check("R8 disabled channel stays low", rises[i], 0);
      else check(divided ? "R6 divided rate" : "R6 undivided rate",
                 (rises[i] >= lo && rises[i] <= hi), 1);
    end
    ref_run = 0;
    cyc(8);
  endtask

  task automatic run_runt(input bit divided);
    logic [7:0] lf = 8'h5A;
    div_sel_n = divided ? 1'b0 : 1'b1;
    reg_en = '1; pol_inv = 0; stop_pin = 1; pdn_pin = 1;
    ref_run = 1;
    cyc(30);
    exp_w = divided ? 4 : 2;
    clear_meas();
    meas = 1;
    for (int k = 0; k < 200; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      chan_en_pin = lf;
      stop_pin = (k % 17 == 5) ? 1'b0 : 1'b1;
      cyc(3);
    end
    meas = 0;
    check("R7 high pulses never shortened", width_bad, 0);
    check("R7 pulses observed", (pulses > 50), 1);
    ref_run = 0;
    stop_pin = 1;
    cyc(8);
  endtask

  initial begin
    logic [NCH-1:0] chan_pat [4];
    logic [NCH-1:0] reg_pat  [3];
    chan_pat[0] = 8'h00; chan_pat[1] = 8'hFF; chan_pat[2] = 8'hA5; chan_pat[3] = 8'h3C;
    reg_pat[0]  = 8'hFF; reg_pat[1]  = 8'h00; reg_pat[2]  = 8'h96;

    cyc(3);
    check("R1 reset clk_out", clk_out, 0);
    check("R1 reset drive", out_drive, 0);
    check("R1 reset lock", lock_out, 0);
    rst = 0;
    @(negedge clk);
    check("R1 first cycle drive", out_drive, 0);
    check("R1 first cycle lock", lock_out, 0);

    // Decode sweep with the reference held low.
    for (int inv = 0; inv < 2; inv++)
      for (int st = 0; st < 2; st++)
        for (int pd = 0; pd < 2; pd++)
          for (int c = 0; c < 4; c++)
            for (int r = 0; r < 3; r++) begin
              logic [NCH-1:0] expv;
              bit gate_off;
              pol_inv = inv[0]; stop_pin = st[0]; pdn_pin = pd[0];
              chan_en_pin = chan_pat[c]; reg_en = reg_pat[r];
              cyc(5);
              gate_off = (st[0] == inv[0]) || (pd[0] == inv[0]);
              expv = gate_off ? '0 : ((chan_pat[c] ^ {NCH{inv[0]}}) & reg_pat[r]);
              if (gate_off)   check("R4 global off", out_drive, expv);
              else if (inv)   check("R3 inverted sense", out_drive, expv);
              else            check("R2 R5 per-channel decode", out_drive, expv);
              check("R8 idle outputs low", clk_out, 0);
            end

    // Synchronizer latency.
    pol_inv = 0; stop_pin = 1; pdn_pin = 1; reg_en = '1; chan_en_pin = '0;
    cyc(6);
    chan_en_pin = 8'hC3;
    @(negedge clk); check("R11 not after one edge", out_drive, 0);
    @(negedge clk); check("R11 not after two edges", out_drive, 0);
    @(negedge clk); check("R11 after three edges", out_drive, 8'hC3);

    // Single register bit off.
    chan_en_pin = '1; reg_en = 8'hEF;
    cyc(5);
    check("R5 one register bit", out_drive, 8'hEF);

    run_count(0);
    run_count(1);
    run_runt(0);
    run_runt(1);

    // Lock latch.
    pol_inv = 0; pdn_pin = 1; div_sel_n = 1;
    check("R9 lock low before", lock_out, 0);
    lock_raw = 1; @(negedge clk); lock_raw = 0;
    cyc(5);
    check("R9 lock set", lock_out, 1);
    cyc(12);
    check("R9 lock held", lock_out, 1);
    pdn_pin = 0;
    cyc(5);
    check("R10 power-down clears lock", lock_out, 0);
    pdn_pin = 1;
    cyc(5);
    check("R10 lock stays clear", lock_out, 0);
    pol_inv = 1; pdn_pin = 0;
    lock_raw = 1; @(negedge clk); lock_raw = 0;
    cyc(6);
    check("R3 inverted power-down inactive", lock_out, 1);
    rst = 1;
    cyc(2);
    check("R10 reset clears lock", lock_out, 0);
    check("R1 reset clears drive", out_drive, 0);
    rst = 0;
    cyc(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

endmodule